// File: doc/BRIEF.md
# Triangular Modulation Profile Generator

This block produces the slowly moving staircase value that drives the input of the sigma-delta modulator in a down-spreading clock generator. In each modulation period the value climbs from zero to a programmable peak one unit at a time, then falls back to zero along the same staircase. The output clock's frequency therefore sweeps between nominal and nominal minus the chosen deviation. The peak sets the spread depth: 19 gives close to −5000 ppm with ten output phases, and 38 gives the same depth with twenty. A smaller peak gives a shallower spread. The number of clocks between steps sets the modulation frequency.

The block runs in the 100 MHz reference-rate domain. One modulation period lasts 2 × peak × interval clocks. With a peak of 19, an interval of 83 gives a period of 31.5 µs, which lies inside the 30–33 kHz window. Peak and interval are captured only at the start of each period. A change written mid-sweep therefore never cuts a triangle short or makes it lopsided.

Top module: `tri_profile_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the output is 0 and the next movement is upward. The first clock after release captures the peak and interval inputs.
- R2: The output changes by exactly 1 once every I clocks, where I is the captured interval. An interval input of 0 is treated as 1.
- R3: Within one period the output rises from 0 to the captured peak P and then falls back to 0 in equal steps. After the t-th clock of the period (t counted from 0 at the capturing clock) the output equals s when s ≤ P and 2P − s otherwise, where s = floor((t+1)/I). The period lasts 2·P·I clocks.
- R4: The peak value and the value 0 are each held for exactly I clocks per period, and the peak is reached once per period.
- R5: Peak and interval are captured only on the first clock of the zero hold, that is, when the output is 0 and a new interval is starting. Changes at any other time have no effect on the current period.
- R6: A peak input above MAX_PEAK (default 38) is captured as MAX_PEAK.
- R7: A captured peak of 0 holds the output at 0, and the inputs are captured again every I clocks.
- R8: A captured peak of 1 makes the output alternate between 0 and 1, holding each value for I clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-rate clock (100 MHz in use) |
| rst_n | input | 1 | Active-low synchronous reset |
| peak_cfg | input | VAL_W | Requested top of the triangle (spread depth) |
| intv_cfg | input | INTV_W | Clocks per staircase step (modulation rate) |
| prof_val | output | VAL_W | Current profile value to the sigma-delta modulator |

## Verification
The hardest case to reach from the ports is a configuration change that arrives in the middle of a sweep. Such a change has to stay invisible until the output next returns to zero, and then take effect cleanly. The bench first lines up on a period boundary, runs part of a slow triangle, and then writes a smaller peak and a longer interval. It checks that the rest of the sweep still climbs to the old peak and that the following period follows the new shape. A reset in the middle of a ramp, and the degenerate peaks 0 and 1, are driven the same way.

// File: rtl/tri_profile_gen.sv
module tri_profile_gen #(
  parameter int VAL_W    = 6,
  parameter int INTV_W   = 12,
  parameter int MAX_PEAK = 38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VAL_W-1:0]  peak_cfg,
  input  logic [INTV_W-1:0] intv_cfg,
  output logic [VAL_W-1:0]  prof_val
);

  localparam logic [VAL_W-1:0]  PK_LIM = VAL_W'(MAX_PEAK);
  localparam logic [INTV_W-1:0] ONE_I  = INTV_W'(1);
  localparam logic [VAL_W-1:0]  ONE_V  = VAL_W'(1);

  logic [VAL_W-1:0]  val_q, peak_q;
  logic [INTV_W-1:0] cnt_q, intv_q;
  logic              dn_q;

  wire               reload   = (val_q == '0) && (cnt_q == '0);
  wire [VAL_W-1:0]   peak_lim = (peak_cfg > PK_LIM) ? PK_LIM : peak_cfg;
  wire [INTV_W-1:0]  intv_lim = (intv_cfg == '0) ? ONE_I : intv_cfg;
  wire [VAL_W-1:0]   peak_eff = reload ? peak_lim : peak_q;
  wire [INTV_W-1:0]  intv_eff = reload ? intv_lim : intv_q;
  wire               step     = (cnt_q == intv_eff - ONE_I);

  assign prof_val = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q  <= '0;
      cnt_q  <= '0;
      dn_q   <= 1'b0;
      peak_q <= '0;
      intv_q <= ONE_I;
    end else begin
      if (reload) begin
        peak_q <= peak_lim;
        intv_q <= intv_lim;
      end
      cnt_q <= step ? '0 : cnt_q + ONE_I;
      if (step && peak_eff != '0) begin
        if (!dn_q) begin
          val_q <= val_q + ONE_V;
          if (val_q + ONE_V == peak_eff) dn_q <= 1'b1;
        end else begin
          val_q <= val_q - ONE_V;
          if (val_q == ONE_V) dn_q <= 1'b0;
        end
      end
    end
  end

  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> ($stable(peak_q) && $stable(intv_q)));

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (val_q == $past(val_q) || val_q == $past(val_q) + ONE_V || val_q + ONE_V == $past(val_q)));

  assert_below_peak_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |-> (val_q <= peak_q));

  assert_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    peak_q <= PK_LIM);

  assert_flat_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_q == '0 && !reload) |=> (val_q == '0));

endmodule

// File: tb/sim_tri_profile_gen.sv
module sim_tri_profile_gen;
  localparam int VAL_W = 6, INTV_W = 12, MAX_PEAK = 38;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [VAL_W-1:0]  peak_cfg = '0;
  logic [INTV_W-1:0] intv_cfg = '0;
  logic [VAL_W-1:0]  prof_val;

  int checks = 0, fails = 0;
  int m_p = 0, m_i = 1, m_t = 0, m_len = 1, exp_v = 0;
  bit done = 0;

  tri_profile_gen #(.VAL_W(VAL_W), .INTV_W(INTV_W), .MAX_PEAK(MAX_PEAK)) u0 (
    .clk(clk), .rst_n(rst_n), .peak_cfg(peak_cfg), .intv_cfg(intv_cfg), .prof_val(prof_val));

  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int tri_at(input int s, input int p);
    return (s <= p) ? s : 2 * p - s;
  endfunction

  task automatic tick(input string tag);
    @(posedge clk);
    if (m_t == 0) begin
      m_p   = (int'(peak_cfg) > MAX_PEAK) ? MAX_PEAK : int'(peak_cfg);
      m_i   = (intv_cfg == '0) ? 1 : int'(intv_cfg);
      m_len = (m_p == 0) ? m_i : 2 * m_p * m_i;
    end
    exp_v = (m_p == 0) ? 0 : tri_at((m_t + 1) / m_i, m_p);
    m_t++;
    if (m_t == m_len) m_t = 0;
    @(negedge clk);
    check(tag, int'(prof_val), exp_v);
  endtask

  task automatic sync_period(input string tag);
    while (m_t != 0) tick(tag);
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 value in reset", int'(prof_val), 0);
    rst_n = 1'b1;
    m_t = 0;
    check("R1 value after release", int'(prof_val), 0);
    tick("R1 first clock");
  endtask

  task automatic test_basic();
    int pk_cnt = 0, zero_cnt = 0, max_v = 0;
    peak_cfg = 6'd19; intv_cfg = 12'd3;
    sync_period("R3 settle");
    for (int k = 0; k < 2 * 2 * 19 * 3; k++) begin
      tick("R3 triangle p19 i3");
      if (prof_val == 6'd19) pk_cnt++;
      if (prof_val == 6'd0) zero_cnt++;
      if (int'(prof_val) > max_v) max_v = int'(prof_val);
    end
    check("R4 clocks at peak over two periods", pk_cnt, 6);
    check("R4 clocks at zero over two periods", zero_cnt, 6);
    check("R2 highest value reached", max_v, 19);
  endtask

  task automatic test_mid_change();
    int max_v = 0;
    peak_cfg = 6'd5; intv_cfg = 12'd2;
    sync_period("R5 settle");
    for (int k = 0; k < 6; k++) tick("R5 before change");
    peak_cfg = 6'd2; intv_cfg = 12'd4;
    while (m_t != 0) begin
      tick("R5 old period continues");
      if (int'(prof_val) > max_v) max_v = int'(prof_val);
    end
    check("R5 mid-period peak change ignored", max_v, 5);
    for (int k = 0; k < 16; k++) tick("R5 new period shape");
    check("R5 new interval in force", m_i, 4);
  endtask

  task automatic test_clamp();
    int max_v = 0;
    peak_cfg = 6'd63; intv_cfg = 12'd1;
    sync_period("R6 settle");
    for (int k = 0; k < 2 * MAX_PEAK; k++) begin
      tick("R6 clamped triangle");
      if (int'(prof_val) > max_v) max_v = int'(prof_val);
    end
    check("R6 peak clamped", max_v, MAX_PEAK);
  endtask

  task automatic test_zero_peak();
    peak_cfg = 6'd0; intv_cfg = 12'd3;
    sync_period("R7 settle");
    for (int k = 0; k < 12; k++) tick("R7 flat at zero");
    peak_cfg = 6'd3; intv_cfg = 12'd0;
    for (int k = 0; k < 3; k++) tick("R7 recapture");
    for (int k = 0; k < 12; k++) tick("R2 interval zero acts as one");
  endtask

  task automatic test_peak_one();
    int ones = 0;
    peak_cfg = 6'd1; intv_cfg = 12'd2;
    sync_period("R8 settle");
    for (int k = 0; k < 12; k++) begin
      tick("R8 alternate");
      if (prof_val == 6'd1) ones++;
    end
    check("R8 clocks at one", ones, 6);
  endtask

  task automatic test_reset_mid();
    peak_cfg = 6'd19; intv_cfg = 12'd2;
    sync_period("R1 settle");
    for (int k = 0; k < 15; k++) tick("R1 ramp before reset");
    test_reset();
    for (int k = 0; k < 20; k++) tick("R1 restart upward");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    peak_cfg = 6'd19; intv_cfg = 12'd3;
    test_reset();
    test_basic();
    test_mid_change();
    test_clamp();
    test_zero_peak();
    test_peak_one();
    test_reset_mid();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule